// File: doc/BRIEF.md
# Card Clock Divider with Gating

This block derives the clock for a memory card from a fast reference clock. A programmable 8-bit divide code sets the card clock period to code+1 reference cycles. Each period starts with a one-cycle strobe, which logic in the reference domain can use as a card clock enable. The visible card clock is a registered level: high for the first half of each period and low for the rest.

The requested code is changed by two overrides before it is used. After card power comes up, a slow-start mode forces a fixed low rate of about 1 MHz. That mode stays until the first bulk transfer finishes without error. When slow operation is requested, the code is multiplied by eight and clamped to the largest code.

The clock is gated. It runs only when card power is on, a nonzero rate is requested, and there is a reason to run: a transfer in progress, the idle-clock policy bit, or slow-start mode. The clock starts and stops only on a period boundary, where the output is low. A new divide code likewise waits for the next period boundary.

Top module: `sdclk_gen_top`

## Requirements
- R1: With effective divide code `d`, the strobe `card_clk_stb` is high for one reference cycle every `d+1` reference cycles. `card_clk` is high for the first `(d+1)>>1` cycles of each period, starting with the strobe cycle, and low for the rest. Code 0 therefore gives a strobe on every cycle with `card_clk` held low.
- R2: A rising edge on `card_pwr` enters slow-start mode. In that mode the effective code is `REF_HZ/SLOW_HZ`, clamped to 255; the default is 50, a period of 51 cycles. This code takes priority over both `div_req` and `slow_req`.
- R3: Slow-start mode ends after a one-cycle pulse on `xfer_ok`. The normal code then applies from the next period boundary. If a power rising edge and `xfer_ok` arrive in the same cycle, the power edge wins.
- R4: Outside slow-start mode, with `slow_req` high, the effective code is `div_req*8`, clamped to 255. For example, 3 gives 24 and 40 gives 255.
- R5: With `clk_en_req` low, meaning a requested rate of zero, the clock stops: no strobes and `card_clk` low.
- R6: The clock runs only while `xfer_active`, `idle_clk_keep` or slow-start mode is true. With all three false, the clock stops after the current period.
- R7: With `card_pwr` low, the clock stops, whatever the other inputs are.
- R8: The clock stops only at the end of a period, so a started high phase is never cut short. When stopped, both outputs are low. From the stopped state, a run condition sampled at a clock edge gives the first strobe in the cycle after that edge.
- R9: A change of the effective code during a period does not change that period. It is taken at the next period boundary.
- R10: During and right after reset, `card_clk` and `card_clk_stb` are low and slow-start mode is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_req | input | DIV_W | Requested divide code |
| clk_en_req | input | 1 | Nonzero rate requested; low stops the clock |
| card_pwr | input | 1 | Card power state; a rising edge enters slow-start |
| xfer_ok | input | 1 | One-cycle pulse: a bulk transfer finished without error |
| slow_req | input | 1 | Apply the x8 slow-down ratio |
| idle_clk_keep | input | 1 | Policy bit: keep the clock running while idle |
| xfer_active | input | 1 | A transfer is in progress |
| card_clk | output | 1 | Gated card clock |
| card_clk_stb | output | 1 | One-cycle strobe at each card clock period start |

## Verification
A behavioural period model in the bench is compared with both outputs on every cycle. Directed sequences go after the priority of slow-start over the x8 ratio, the clamp at 255, and codes 0 and 1. A design that took the new code at once would give a short period right after the change. One that stopped the clock at once would leave a runt high pulse. One that dropped the power-edge priority would stay at the requested rate after power-up. Each case is also checked through the measured period and high time, or through the count of strobes over a long stopped window.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    // Clamp a computed divide code to the largest code a field can hold.
    function automatic int clamp_code(input int value, input int limit);
        return (value > limit) ? limit : value;
    endfunction

endpackage

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel #(
    parameter int DIV_W      = 8,
    parameter int SLOW_SHIFT = 3,
    parameter int SLOW_DIV   = 50
) (
    input  logic             slow_mode,
    input  logic             slow_req,
    input  logic [DIV_W-1:0] div_req,
    output logic [DIV_W-1:0] eff_div
);
    localparam logic [DIV_W-1:0] SLOW_CODE = DIV_W'(SLOW_DIV);
    localparam int               WIDE_W    = DIV_W + SLOW_SHIFT;

    logic [DIV_W-1:0] scaled;

    generate
        if (SLOW_SHIFT == 0) begin : g_noscale
            assign scaled = div_req;
        end else begin : g_scale
            logic [WIDE_W-1:0] wide;
            always_comb begin
                wide   = {{SLOW_SHIFT{1'b0}}, div_req} << SLOW_SHIFT;
                scaled = (|wide[WIDE_W-1:DIV_W]) ? {DIV_W{1'b1}} : wide[DIV_W-1:0];
            end
        end
    endgenerate

    // Priority: slow-start, then scaled ratio, then request as given.
    always_comb begin
        if (slow_mode)     eff_div = SLOW_CODE;
        else if (slow_req) eff_div = scaled;
        else               eff_div = div_req;
    end

    always_comb begin
        if (slow_req && !slow_mode) begin
            AST_SCALE_MONOTONIC: assert (eff_div >= div_req); // R4
        end
    end

endmodule

// File: rtl/sdclk_slow_ctl.sv
module sdclk_slow_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic card_pwr,
    input  logic xfer_ok,
    output logic slow_mode
);
    typedef struct packed {
        logic pwr_prev;
        logic slow;
    } slow_st_t;

    slow_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.pwr_prev = card_pwr;
        if (card_pwr && !st_q.pwr_prev) st_d.slow = 1'b1;
        else if (xfer_ok)               st_d.slow = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slow_mode = st_q.slow;

    AST_SLOW_ON_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_pwr) |=> slow_mode); // R2

endmodule

// File: rtl/sdclk_period_gen.sv
module sdclk_period_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want_run,
    input  logic [DIV_W-1:0] eff_div,
    output logic             card_clk,
    output logic             card_clk_stb
);
    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             clk;
        logic             stb;
    } gen_st_t;

    gen_st_t        st_d, st_q;
    logic           at_end;
    logic [DIV_W:0] hi_len;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == st_q.div);
        if (st_q.run) begin
            if (at_end) begin
                st_d.cnt = '0;
                st_d.div = eff_div;
                st_d.run = want_run;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (want_run) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
            st_d.div = eff_div;
        end
        hi_len   = ({1'b0, st_d.div} + {{DIV_W{1'b0}}, 1'b1}) >> 1;
        st_d.clk = st_d.run && ({1'b0, st_d.cnt} < hi_len);
        st_d.stb = st_d.run && (st_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign card_clk     = st_q.clk;
    assign card_clk_stb = st_q.stb;

    AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> $past(st_q.cnt == st_q.div)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (!card_clk && !card_clk_stb)); // R8
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && st_q.cnt != '0) |-> $stable(st_q.div)); // R9
    AST_RISE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> card_clk_stb); // R1

endmodule

// File: rtl/sdclk_gen_top.sv
module sdclk_gen_top #(
    parameter int DIV_W      = 8,
    parameter int REF_HZ     = 50_000_000,
    parameter int SLOW_HZ    = 1_000_000,
    parameter int SLOW_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_req,
    input  logic             clk_en_req,
    input  logic             card_pwr,
    input  logic             xfer_ok,
    input  logic             slow_req,
    input  logic             idle_clk_keep,
    input  logic             xfer_active,
    output logic             card_clk,
    output logic             card_clk_stb
);
    localparam int CODE_MAX = (1 << DIV_W) - 1;
    localparam int SLOW_DIV = sdclk_pkg::clamp_code(REF_HZ / SLOW_HZ, CODE_MAX);

    logic             slow_mode;
    logic [DIV_W-1:0] eff_div;
    logic             want_run;

    sdclk_slow_ctl u_slow (
        .clk       (clk),
        .rst_n     (rst_n),
        .card_pwr  (card_pwr),
        .xfer_ok   (xfer_ok),
        .slow_mode (slow_mode)
    );

    sdclk_ratio_sel #(
        .DIV_W      (DIV_W),
        .SLOW_SHIFT (SLOW_SHIFT),
        .SLOW_DIV   (SLOW_DIV)
    ) u_ratio (
        .slow_mode (slow_mode),
        .slow_req  (slow_req),
        .div_req   (div_req),
        .eff_div   (eff_div)
    );

    assign want_run = card_pwr && clk_en_req && (xfer_active || idle_clk_keep || slow_mode);

    sdclk_period_gen #(
        .DIV_W (DIV_W)
    ) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .want_run     (want_run),
        .eff_div      (eff_div),
        .card_clk     (card_clk),
        .card_clk_stb (card_clk_stb)
    );

    AST_NO_START_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_pwr && !card_clk_stb) |=> !card_clk_stb); // R7
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_req && !card_clk_stb && !card_clk) |=> !card_clk_stb); // R5

endmodule

// File: tb/sdclk_gen_top_tb_top.sv
module sdclk_gen_top_tb_top;
    localparam int SLOW_CODE = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_req = 8'd4;
    logic       clk_en_req = 1'b1;
    logic       card_pwr = 1'b0;
    logic       xfer_ok = 1'b0;
    logic       slow_req = 1'b0;
    logic       idle_clk_keep = 1'b1;
    logic       xfer_active = 1'b0;
    logic       card_clk;
    logic       card_clk_stb;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    finished = 0;
    string cur_req = "R10";

    // behavioural reference model state
    int m_run = 0, m_pos = 0, m_len = 1, m_slow = 0, m_pprev = 0;
    int m_eff;
    bit m_want;

    always #5 clk = ~clk;

    sdclk_gen_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_req       (div_req),
        .clk_en_req    (clk_en_req),
        .card_pwr      (card_pwr),
        .xfer_ok       (xfer_ok),
        .slow_req      (slow_req),
        .idle_clk_keep (idle_clk_keep),
        .xfer_active   (xfer_active),
        .card_clk      (card_clk),
        .card_clk_stb  (card_clk_stb)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pos = 0; m_len = 1; m_slow = 0; m_pprev = 0;
        end else begin
            if (m_slow != 0)   m_eff = SLOW_CODE;
            else if (slow_req) m_eff = (int'(div_req) * 8 > 255) ? 255 : int'(div_req) * 8;
            else               m_eff = int'(div_req);
            m_want = card_pwr && clk_en_req && (xfer_active || idle_clk_keep || m_slow != 0);
            if (m_run != 0) begin
                if (m_pos == m_len - 1) begin
                    m_pos = 0; m_len = m_eff + 1; m_run = m_want ? 1 : 0;
                end else begin
                    m_pos = m_pos + 1;
                end
            end else if (m_want) begin
                m_run = 1; m_pos = 0; m_len = m_eff + 1;
            end
            if (card_pwr && m_pprev == 0) m_slow = 1;
            else if (xfer_ok)             m_slow = 0;
            m_pprev = card_pwr ? 1 : 0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int e_clk, e_stb;
            e_clk = (m_run != 0 && m_pos < (m_len / 2)) ? 1 : 0;
            e_stb = (m_run != 0 && m_pos == 0) ? 1 : 0;
            chk(cur_req, "card_clk vs model (R8 R1)", int'(card_clk), e_clk);
            chk(cur_req, "card_clk_stb vs model (R8 R1)", int'(card_clk_stb), e_stb);
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            finish_run();
        end
    end

    task automatic wait_stb();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!card_clk_stb && n < 600);
        if (n >= 600) chk(cur_req, "strobe timeout", 0, 1);
    endtask

    task automatic gap(output int len, output int hi);
        len = 0;
        hi = 0;
        do begin
            if (card_clk) hi++;
            @(negedge clk);
            len++;
        end while (!card_clk_stb && len < 600);
    endtask

    task automatic count_win(input int n, output int s, output int h);
        s = 0;
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (card_clk_stb) s++;
            if (card_clk) h++;
        end
    endtask

    task automatic measure(input string req, input int exp_len, input int exp_hi);
        int len, hi;
        cur_req = req;
        wait_stb();
        gap(len, hi);
        gap(len, hi);
        chk(req, "period", len, exp_len);
        chk(req, "high time", hi, exp_hi);
    endtask

    initial begin
        int len, hi, s, h;
        // R10: outputs quiet during reset
        repeat (4) @(negedge clk);
        chk("R10", "card_clk in reset", int'(card_clk), 0);
        chk("R10", "stb in reset", int'(card_clk_stb), 0);
        rst_n = 1'b1;
        count_win(20, s, h);
        chk("R10", "strobes after reset, unpowered", s, 0);

        // R2: power-up forces slow-start rate over div_req=4
        cur_req = "R2";
        card_pwr = 1'b1;
        measure("R2", SLOW_CODE + 1, (SLOW_CODE + 1) / 2);

        // R3: good transfer ends slow-start, requested rate returns (R1)
        cur_req = "R3";
        xfer_ok = 1'b1;
        @(negedge clk);
        xfer_ok = 1'b0;
        measure("R3", 5, 2);

        // R9: change mid-period keeps the current period
        cur_req = "R9";
        wait_stb();
        div_req = 8'd9;
        gap(len, hi);
        chk("R9", "period in flight", len, 5);
        gap(len, hi);
        chk("R9", "period after boundary", len, 10);
        chk("R9", "high time after boundary", hi, 5);

        // R1: smallest codes
        div_req = 8'd0;
        measure("R1", 1, 0);
        div_req = 8'd1;
        measure("R1", 2, 1);

        // R4: x8 ratio and clamp
        slow_req = 1'b1;
        div_req = 8'd3;
        measure("R4", 25, 12);
        div_req = 8'd40;
        measure("R4", 256, 128);
        div_req = 8'd31;
        measure("R4", 249, 124);

        // R7: power off stops the clock
        cur_req = "R7";
        div_req = 8'd3;
        card_pwr = 1'b0;
        repeat (300) @(negedge clk);
        count_win(300, s, h);
        chk("R7", "strobes while unpowered", s, 0);
        chk("R7", "high cycles while unpowered", h, 0);

        // R2 priority over slow_req, then R3 restores x8 rate
        card_pwr = 1'b1;
        measure("R2", SLOW_CODE + 1, (SLOW_CODE + 1) / 2);
        xfer_ok = 1'b1;
        @(negedge clk);
        xfer_ok = 1'b0;
        measure("R3", 25, 12);
        slow_req = 1'b0;
        div_req = 8'd4;

        // R5: zero rate stops; restart latency (R8)
        cur_req = "R5";
        clk_en_req = 1'b0;
        repeat (300) @(negedge clk);
        count_win(300, s, h);
        chk("R5", "strobes with rate zero", s, 0);
        chk("R5", "high cycles with rate zero", h, 0);
        clk_en_req = 1'b1;
        @(negedge clk);
        chk("R8", "first strobe one cycle after start", int'(card_clk_stb), 1);

        // R6: idle gating
        cur_req = "R6";
        idle_clk_keep = 1'b0;
        repeat (300) @(negedge clk);
        count_win(300, s, h);
        chk("R6", "strobes while idle without keep", s, 0);
        xfer_active = 1'b1;
        @(negedge clk);
        chk("R6", "strobe on transfer start", int'(card_clk_stb), 1);
        xfer_active = 1'b0;
        repeat (20) @(negedge clk);
        count_win(100, s, h);
        chk("R6", "strobes after transfer ends", s, 0);
        idle_clk_keep = 1'b1;
        count_win(300, s, h);
        chk("R6", "strobes with keep policy", s, 60);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule